// File: doc/BRIEF.md
# SMI Enable Register with Source Gating

This block holds the 32-bit SMI enable register of a power-management unit and the logic that decides whether an incoming event becomes a system-management interrupt. Six event sources arrive as single-cycle pulses:
- a vendor-specific USB2 event
- a legacy USB2 event
- a periodic tick
- a TCO event
- a trap on microcontroller port accesses
- a write to the APM command port

Each source passes only when its enable bit is set. An NMI that has been rerouted to SMI skips the TCO gate entirely.

Software reaches the register through a plain write strobe and a read-data bus. A write-only release bit in the register sets a global status flag, and that flag drives an SCI request directly. A software one-shot timer starts when its enable bit is set. It fires once, after one of four parameter-chosen cycle counts picked by a 2-bit rate input. On expiry it sets a timer status flag and requests an SMI. The SMI request is sticky: it stays high until an end-of-SMI pulse clears it.

Top module: `smi_gate`

## Requirements
- R1: After reset, rd_data is 0, and smi_req, sci_req, glb_sts and swt_sts are all 0.
- R2: Only these bits are writable, and each reads back the last value written: 18 (USB2 vendor enable), 17 (USB2 legacy enable), 14 (periodic enable), 13 (TCO enable), 11 (port-trap enable), 6 (timer enable) and 5 (APM enable). Every other bit reads 0 and ignores writes.
- R3: Bit 7 is the release bit. It always reads 0. Writing 1 to it sets glb_sts on the next clock edge, and writing 0 to it has no effect. A glb_clr pulse clears glb_sts, but a release write in the same cycle wins.
- R4: sci_req is high whenever glb_sts is high. No other enable is involved.
- R5: While tco_lock is 1, bit 13 keeps its value across writes. The other writable bits still update.
- R6: A source pulse whose enable bit is 1 makes smi_req high after the next edge. A pulse whose enable bit is 0 does not.
- R7: An ev_nmi pulse with nmi2smi_en = 1 makes smi_req high whatever the value of bit 13. With nmi2smi_en = 0, an ev_nmi pulse does nothing.
- R8: smi_req stays high until an eos pulse. It goes low after that edge unless a new SMI cause arrives in the same cycle.
- R9: Exactly L edges after bit 6 goes from 0 to 1, swt_sts goes high and smi_req goes high. L is the selected timeout.
- R10: Clearing bit 6 before expiry cancels the count with no status set. A later set of bit 6 counts a full L again.
- R11: The timer fires once per enable. After expiry it stays idle while bit 6 stays set, and bit 6 keeps reading 1. swt_clr clears swt_sts.
- R12: The rate_sel value 0, 1, 2 or 3 selects the timeout TICK_0, TICK_1, TICK_2 or TICK_3 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| tco_lock | input | 1 | Freezes the TCO enable bit |
| nmi2smi_en | input | 1 | Lets rerouted NMIs raise SMI |
| rate_sel | input | 2 | Timer timeout select |
| ev_usb_vnd | input | 1 | Vendor-specific USB2 event pulse |
| ev_usb_leg | input | 1 | Legacy USB2 event pulse |
| ev_periodic | input | 1 | Periodic event pulse |
| ev_tco | input | 1 | TCO event pulse |
| ev_mc_trap | input | 1 | Microcontroller port trap pulse |
| ev_apm_wr | input | 1 | APM command write pulse |
| ev_nmi | input | 1 | Rerouted NMI pulse |
| eos | input | 1 | End-of-SMI, clears smi_req |
| glb_clr | input | 1 | Clears glb_sts |
| swt_clr | input | 1 | Clears swt_sts |
| smi_req | output | 1 | Sticky SMI request |
| sci_req | output | 1 | SCI request |
| glb_sts | output | 1 | Global status flag |
| swt_sts | output | 1 | Software timer status flag |

## Verification
The properties assume that every event input is a one-cycle pulse sampled on the rising edge, and that rd_data reflects the register contents without any side effect of reading. They also assume rate_sel does not change while the timer is counting. The stimulus respects this by changing rate_sel only in directed steps where bit 6 is clear, and by holding it fixed during the random phase. Random traffic mixes writes, locks, clears and source pulses against a cycle-level model. Directed cases cover the lock, the NMI bypass, the timer's cancel-and-restart, its single shot, and each timeout.

// File: rtl/smi_gate_pkg.sv
package smi_gate_pkg;
    localparam int REG_W  = 32;
    localparam int NSRC   = 6;
    localparam int B_USBV = 18;
    localparam int B_USBL = 17;
    localparam int B_PER  = 14;
    localparam int B_TCO  = 13;
    localparam int B_MCT  = 11;
    localparam int B_REL  = 7;
    localparam int B_SWT  = 6;
    localparam int B_APM  = 5;

    // enable bit position of each gated source, index = source number
    localparam int SRC_POS [NSRC] = '{B_USBV, B_USBL, B_PER, B_TCO, B_MCT, B_APM};

    localparam logic [REG_W-1:0] RW_MASK =
        (REG_W'(1) << B_USBV) | (REG_W'(1) << B_USBL) | (REG_W'(1) << B_PER) |
        (REG_W'(1) << B_TCO)  | (REG_W'(1) << B_MCT)  | (REG_W'(1) << B_SWT) |
        (REG_W'(1) << B_APM);

    typedef struct packed {
        logic [REG_W-1:0] en;
        logic             glb;
    } enreg_st_t;

    typedef struct packed {
        logic smi;
        logic swt;
    } gate_st_t;
endpackage

// File: rtl/smi_enreg.sv
module smi_enreg
    import smi_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             tco_lock,
    input  logic             glb_clr,
    output logic [REG_W-1:0] en_bits,
    output logic             glb_sts
);
    enreg_st_t st_d, st_q;
    logic [REG_W-1:0] wmask;
    logic             rel_hit;

    always_comb begin
        st_d    = st_q;
        wmask   = RW_MASK;
        if (tco_lock) wmask[B_TCO] = 1'b0;
        rel_hit = wr_en & wr_data[B_REL];
        if (wr_en) st_d.en = (st_q.en & ~wmask) | (wr_data & wmask);
        st_d.glb = (st_q.glb & ~glb_clr) | rel_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_bits = st_q.en;
    assign glb_sts = st_q.glb;
endmodule

// File: rtl/smi_swtimer.sv
module smi_swtimer #(
    parameter int unsigned TICK_0 = 16,
    parameter int unsigned TICK_1 = 64,
    parameter int unsigned TICK_2 = 256,
    parameter int unsigned TICK_3 = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate_sel,
    output logic       expire
);
    localparam int unsigned MAX01 = (TICK_0 > TICK_1) ? TICK_0 : TICK_1;
    localparam int unsigned MAX23 = (TICK_2 > TICK_3) ? TICK_2 : TICK_3;
    localparam int unsigned MAXT  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int          CW    = $clog2(MAXT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fired;
    } tmr_st_t;

    tmr_st_t       st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        case (rate_sel)
            2'd0:    lim = CW'(TICK_0);
            2'd1:    lim = CW'(TICK_1);
            2'd2:    lim = CW'(TICK_2);
            default: lim = CW'(TICK_3);
        endcase
        expire = run & ~st_q.fired & (st_q.cnt == lim - CW'(1));
        st_d   = st_q;
        if (!run) begin
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end else if (expire) begin
            st_d.cnt   = '0;
            st_d.fired = 1'b1;
        end else if (!st_q.fired) begin
            st_d.cnt   = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/smi_source_gate.sv
module smi_source_gate
    import smi_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] en_bits,
    input  logic [NSRC-1:0]  ev_src,
    input  logic             ev_nmi,
    input  logic             nmi2smi_en,
    input  logic             tmr_expire,
    input  logic             eos,
    input  logic             swt_clr,
    output logic             smi_req,
    output logic             swt_sts
);
    logic [NSRC-1:0] gated;
    logic            any_hit;
    gate_st_t        st_d, st_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_gate
        assign gated[i] = ev_src[i] & en_bits[SRC_POS[i]];
    end

    always_comb begin
        any_hit = (|gated) | (ev_nmi & nmi2smi_en) | tmr_expire;
        st_d.smi = (st_q.smi & ~eos) | any_hit;
        st_d.swt = (st_q.swt & ~swt_clr) | tmr_expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smi_req = st_q.smi;
    assign swt_sts = st_q.swt;
endmodule

// File: rtl/smi_gate.sv
module smi_gate
    import smi_gate_pkg::*;
#(
    parameter int unsigned TICK_0 = 16,
    parameter int unsigned TICK_1 = 64,
    parameter int unsigned TICK_2 = 256,
    parameter int unsigned TICK_3 = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        tco_lock,
    input  logic        nmi2smi_en,
    input  logic [1:0]  rate_sel,
    input  logic        ev_usb_vnd,
    input  logic        ev_usb_leg,
    input  logic        ev_periodic,
    input  logic        ev_tco,
    input  logic        ev_mc_trap,
    input  logic        ev_apm_wr,
    input  logic        ev_nmi,
    input  logic        eos,
    input  logic        glb_clr,
    input  logic        swt_clr,
    output logic        smi_req,
    output logic        sci_req,
    output logic        glb_sts,
    output logic        swt_sts
);
    logic [REG_W-1:0] en_bits;
    logic [NSRC-1:0]  ev_src;
    logic             tmr_expire;

    // order follows SRC_POS in the package
    assign ev_src = {ev_apm_wr, ev_mc_trap, ev_tco, ev_periodic, ev_usb_leg, ev_usb_vnd};

    smi_enreg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .tco_lock (tco_lock),
        .glb_clr  (glb_clr),
        .en_bits  (en_bits),
        .glb_sts  (glb_sts)
    );

    smi_swtimer #(
        .TICK_0 (TICK_0),
        .TICK_1 (TICK_1),
        .TICK_2 (TICK_2),
        .TICK_3 (TICK_3)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en_bits[B_SWT]),
        .rate_sel (rate_sel),
        .expire   (tmr_expire)
    );

    smi_source_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_bits    (en_bits),
        .ev_src     (ev_src),
        .ev_nmi     (ev_nmi),
        .nmi2smi_en (nmi2smi_en),
        .tmr_expire (tmr_expire),
        .eos        (eos),
        .swt_clr    (swt_clr),
        .smi_req    (smi_req),
        .swt_sts    (swt_sts)
    );

    assign rd_data = en_bits & RW_MASK;
    assign sci_req = glb_sts;
endmodule

// File: rtl/smi_gate_chk.sv
module smi_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        tco_lock,
    input logic        nmi2smi_en,
    input logic        ev_apm_wr,
    input logic        ev_usb_vnd,
    input logic        ev_nmi,
    input logic        eos,
    input logic        smi_req,
    input logic        sci_req,
    input logic        glb_sts,
    input logic        swt_sts
);
    AST_RELEASE_SETS_GLB: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7]) |=> glb_sts); // R3
    AST_RELEASE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[7]); // R3
    AST_RELEASE_RAISES_SCI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7]) |=> sci_req); // R4
    AST_TCO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        tco_lock |=> $stable(rd_data[13])); // R5
    AST_APM_GATED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_apm_wr && rd_data[5]) |=> smi_req); // R6
    AST_USBV_GATED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_usb_vnd && rd_data[18]) |=> smi_req); // R6
    AST_NMI_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nmi && nmi2smi_en) |=> smi_req); // R7
    AST_SMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_req && !eos) |=> smi_req); // R8
    AST_TIMER_RAISES_SMI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swt_sts) |-> smi_req); // R9
endmodule

bind smi_gate smi_gate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .tco_lock   (tco_lock),
    .nmi2smi_en (nmi2smi_en),
    .ev_apm_wr  (ev_apm_wr),
    .ev_usb_vnd (ev_usb_vnd),
    .ev_nmi     (ev_nmi),
    .eos        (eos),
    .smi_req    (smi_req),
    .sci_req    (sci_req),
    .glb_sts    (glb_sts),
    .swt_sts    (swt_sts)
);

// File: tb/sim_smi_gate.sv
`timescale 1ns/1ps
module sim_smi_gate;
    localparam int T0 = 5, T1 = 9, T2 = 14, T3 = 20;
    localparam logic [31:0] MASK = 32'h0006_6860;

    logic        clk = 0, rst_n = 0;
    logic        wr_en = 0, tco_lock = 0, nmi2smi_en = 0;
    logic [31:0] wr_data = 0;
    logic [1:0]  rate_sel = 0;
    logic        ev_usb_vnd = 0, ev_usb_leg = 0, ev_periodic = 0, ev_tco = 0;
    logic        ev_mc_trap = 0, ev_apm_wr = 0, ev_nmi = 0;
    logic        eos = 0, glb_clr = 0, swt_clr = 0;
    logic [31:0] rd_data;
    logic        smi_req, sci_req, glb_sts, swt_sts;

    int unsigned n_chk = 0, n_bad = 0;
    bit          done = 0;

    logic [31:0] m_en;
    logic        m_glb, m_swt, m_smi, m_fired;
    int          m_cnt;

    always #2 clk = ~clk;

    smi_gate #(.TICK_0(T0), .TICK_1(T1), .TICK_2(T2), .TICK_3(T3)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tco_lock(tco_lock), .nmi2smi_en(nmi2smi_en), .rate_sel(rate_sel),
        .ev_usb_vnd(ev_usb_vnd), .ev_usb_leg(ev_usb_leg), .ev_periodic(ev_periodic),
        .ev_tco(ev_tco), .ev_mc_trap(ev_mc_trap), .ev_apm_wr(ev_apm_wr), .ev_nmi(ev_nmi),
        .eos(eos), .glb_clr(glb_clr), .swt_clr(swt_clr), .smi_req(smi_req),
        .sci_req(sci_req), .glb_sts(glb_sts), .swt_sts(swt_sts));

    function automatic int lim_of(input logic [1:0] rs);
        case (rs)
            2'd0: return T0;
            2'd1: return T1;
            2'd2: return T2;
            default: return T3;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic clear_inputs();
        wr_en = 0; wr_data = 0; ev_usb_vnd = 0; ev_usb_leg = 0; ev_periodic = 0;
        ev_tco = 0; ev_mc_trap = 0; ev_apm_wr = 0; ev_nmi = 0;
        eos = 0; glb_clr = 0; swt_clr = 0;
    endtask

    // one clock: predict from requirements, let the edge pass, compare, clear pulses
    task automatic step();
        logic [31:0] wm, en_n;
        logic hit, expire;
        expire = m_en[6] && !m_fired && (m_cnt + 1 == lim_of(rate_sel));
        hit = (ev_usb_vnd & m_en[18]) | (ev_usb_leg & m_en[17]) | (ev_periodic & m_en[14]) |
              (ev_tco & m_en[13]) | (ev_mc_trap & m_en[11]) | (ev_apm_wr & m_en[5]) |
              (ev_nmi & nmi2smi_en) | expire;
        wm = MASK;
        if (tco_lock) wm[13] = 1'b0;
        en_n = wr_en ? ((m_en & ~wm) | (wr_data & wm)) : m_en;
        if (!m_en[6]) begin m_cnt = 0; m_fired = 0; end
        else if (expire) begin m_cnt = 0; m_fired = 1; end
        else if (!m_fired) m_cnt = m_cnt + 1;
        m_smi = (m_smi & ~eos) | hit;
        m_swt = (m_swt & ~swt_clr) | expire;
        m_glb = (m_glb & ~glb_clr) | (wr_en & wr_data[7]);
        m_en  = en_n;
        @(posedge clk); #1;
        chk("R2 rd_data", rd_data, m_en);
        chk("R6 smi_req", {31'b0, smi_req}, {31'b0, m_smi});
        chk("R4 sci_req", {31'b0, sci_req}, {31'b0, m_glb});
        chk("R3 glb_sts", {31'b0, glb_sts}, {31'b0, m_glb});
        chk("R9 swt_sts", {31'b0, swt_sts}, {31'b0, m_swt});
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1; wr_data = d; step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        m_en = 0; m_glb = 0; m_swt = 0; m_smi = 0; m_fired = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 outs", {28'b0, smi_req, sci_req, glb_sts, swt_sts}, 32'h0);
        @(negedge clk);

        // R2: writable bits and reserved bits
        wr(32'hFFFF_FFFF);
        chk("R2 all-ones readback", rd_data, MASK);
        chk("R3 release sets glb", {31'b0, glb_sts}, 32'h1);
        wr(32'h0);
        glb_clr = 1; eos = 1; wr(32'h0);
        chk("R3 zero write no effect", {31'b0, glb_sts}, 32'h0);

        // R5: tco lock
        tco_lock = 1; wr(32'h0000_2020);
        chk("R5 locked set ignored", {31'b0, rd_data[13]}, 32'h0);
        chk("R5 other bit written", {31'b0, rd_data[5]}, 32'h1);
        tco_lock = 0; wr(32'h0000_2000);
        tco_lock = 1; wr(32'h0);
        chk("R5 locked clear ignored", {31'b0, rd_data[13]}, 32'h1);
        tco_lock = 0; wr(32'h0);

        // R7: NMI bypass and its gate
        eos = 1; step();
        nmi2smi_en = 1; ev_nmi = 1; step();
        chk("R7 nmi with bypass", {31'b0, smi_req}, 32'h1);
        eos = 1; step();
        nmi2smi_en = 0; ev_nmi = 1; step();
        chk("R7 nmi without bypass", {31'b0, smi_req}, 32'h0);

        // R6: disabled source is blocked
        ev_tco = 1; ev_apm_wr = 1; step();
        chk("R6 disabled sources", {31'b0, smi_req}, 32'h0);

        // R8: sticky and end-of-SMI
        wr(32'h0000_0800);
        ev_mc_trap = 1; step();
        repeat (3) step();
        chk("R8 held", {31'b0, smi_req}, 32'h1);
        eos = 1; ev_mc_trap = 1; step();
        chk("R8 new cause wins", {31'b0, smi_req}, 32'h1);
        eos = 1; step();
        chk("R8 cleared", {31'b0, smi_req}, 32'h0);
        wr(32'h0);

        // R10: cancel and restart
        rate_sel = 0;
        wr(32'h40); repeat (3) step();
        wr(32'h0); step();
        wr(32'h40);
        repeat (T0 - 1) step();
        chk("R10 no early expiry", {31'b0, swt_sts}, 32'h0);
        step();
        chk("R9 expiry status", {31'b0, swt_sts}, 32'h1);
        chk("R9 expiry smi", {31'b0, smi_req}, 32'h1);

        // R11: single shot
        swt_clr = 1; eos = 1; step();
        repeat (2 * T3) step();
        chk("R11 no refire sts", {31'b0, swt_sts}, 32'h0);
        chk("R11 no refire smi", {31'b0, smi_req}, 32'h0);
        chk("R11 enable kept", {31'b0, rd_data[6]}, 32'h1);

        // R12: each rate select
        for (int rs = 0; rs < 4; rs++) begin
            wr(32'h0);
            rate_sel = 2'(rs);
            swt_clr = 1; wr(32'h40);
            n = 0;
            while (!swt_sts && n < 100) begin step(); n++; end
            chk("R12 timeout length", 32'(n), 32'(lim_of(2'(rs))));
        end
        wr(32'h0);

        // random phase against the model
        rate_sel = 1;
        for (int i = 0; i < 3000; i++) begin
            wr_en       = ($urandom % 4) == 0;
            wr_data     = $urandom;
            wr_data[6]  = ($urandom % 4) == 0;
            if (($urandom % 16) == 0) tco_lock = ~tco_lock;
            nmi2smi_en  = $urandom % 2;
            ev_usb_vnd  = ($urandom % 8) == 0;
            ev_usb_leg  = ($urandom % 8) == 0;
            ev_periodic = ($urandom % 8) == 0;
            ev_tco      = ($urandom % 8) == 0;
            ev_mc_trap  = ($urandom % 8) == 0;
            ev_apm_wr   = ($urandom % 8) == 0;
            ev_nmi      = ($urandom % 10) == 0;
            eos         = ($urandom % 3) == 0;
            glb_clr     = ($urandom % 6) == 0;
            swt_clr     = ($urandom % 8) == 0;
            step();
        end
        finish_run();
    end
endmodule